// File: doc/BRIEF.md
# Filter-Result Destination Router

This block sits behind a programmable filter compute engine. Each time the engine produces a result, it presents a valid-qualified I/Q pair and the destination field of the instruction that made it. The router decodes that field sample by sample and sends the pair to one or two of three consumers:

- the recirculation port back into the filter engine;
- the FIFO/AGC path, which later drives the I1/Q1 outputs;
- the direct/cascade output, which carries I2/Q2 to a following stage.

On the same cycle it raises single-cycle control pulses for the AGC loop, the serial output section and the magnitude/phase feedback request. Every output is registered, so all results appear one clock after the input sample is accepted.

The destination field is 11 bits wide and is taken from instruction bits 28 down to 18. In this document the field's own bit numbers are used, with bit 10 corresponding to instruction bit 28.

Top module: `filterDestRouter`

## Requirements
- R1: While `rstN` is low, and in the first cycle after its release, every valid and pulse output is 0 and every data output and `fbStep` is 0.
- R2: The path select sits in field bits 8:7. A valid sample with path select 00 produces `fbValid`=1 and `fbI`/`fbQ` equal to the input one clock later, with `agcValid` and `casValid` at 0.
- R3: A valid sample with path select 01 produces `agcValid`=1 and `agcI`/`agcQ` equal to the input one clock later, with `fbValid` and `casValid` at 0.
- R4: A valid sample with path select 10 produces `casValid`=1 and `casI`/`casQ` equal to the input one clock later, with `fbValid` and `agcValid` at 0.
- R5: A valid sample with path select 11 (test mode) drives both the feedback and the cascade outputs with the sample one clock later, and leaves `agcValid` at 0.
- R6: `agcGainSel` (field bit 10) and `agcUpdate` (field bit 9) each pulse one clock after a valid sample only if that bit is 1 and the path select is 01. Otherwise both stay 0.
- R7: `outStrobe` pulses one clock after a valid sample whose field bit 6 is 1, on any path.
- R8: `polarFbReq` pulses one clock after a valid sample whose field bit 5 is 1, on any path.
- R9: `fbStep` takes field bits 4:0 in the same cycle that a feedback write is presented, and holds that value until the next feedback write.
- R10: When `inValid` is 0, no valid or pulse output is raised one clock later, whatever the field contains.
- R11: The data registers of a path that is not selected keep their previous contents.
- R12: Samples on consecutive cycles are routed independently, each by its own field, with no gap needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Filter result valid |
| inI | input | DATA_W | Result in-phase component |
| inQ | input | DATA_W | Result quadrature component |
| inDest | input | STEP_W+6 | Destination field of the producing instruction |
| fbValid | output | 1 | Write strobe into the recirculation port |
| fbI | output | DATA_W | Recirculated in-phase data |
| fbQ | output | DATA_W | Recirculated quadrature data |
| fbStep | output | STEP_W | Sequence step number tagged on the feedback write |
| agcValid | output | 1 | Sample strobe into the FIFO/AGC path |
| agcI | output | DATA_W | FIFO/AGC in-phase data |
| agcQ | output | DATA_W | FIFO/AGC quadrature data |
| agcGainSel | output | 1 | AGC loop gain select pulse |
| agcUpdate | output | 1 | AGC loop update pulse |
| casValid | output | 1 | Direct/cascade output strobe |
| casI | output | DATA_W | Cascade in-phase data |
| casQ | output | DATA_W | Cascade quadrature data |
| outStrobe | output | 1 | Start serial output with this sample |
| polarFbReq | output | 1 | Request magnitude/phase feedback into the engine |

## Verification
The bench sets the AGC control bits on every non-AGC path select. A router that forgot the gating would raise gain or update pulses on feedback or cascade samples. It drives invalid cycles with a busy field; a design that decoded without the valid qualifier would emit phantom strobes there. Test mode 11 is checked for fan-out to both feedback and cascade but not to AGC, which catches a decoder that treats the path bits as a plain one-hot. It also checks that data and step registers of unselected paths hold across later samples, and that back-to-back samples with different fields each land on their own path.

// File: rtl/routerPkg.sv
package routerPkg;

  // Path select codes carried in the destination field.
  typedef enum logic [1:0] {
    SEL_FEEDBACK  = 2'b00,
    SEL_AGC       = 2'b01,
    SEL_CASCADE   = 2'b10,
    SEL_TEST_BOTH = 2'b11
  } pathSel_e;

  localparam int NUM_PATHS = 3;
  localparam int IDX_FB    = 0;
  localparam int IDX_AGC   = 1;
  localparam int IDX_CAS   = 2;

  // Width of the control part of the field (everything above the step number).
  localparam int CTL_W      = 6;
  localparam int CTL_GAIN   = 5;
  localparam int CTL_UPDATE = 4;
  localparam int CTL_SEL_HI = 3;
  localparam int CTL_SEL_LO = 2;
  localparam int CTL_STROBE = 1;
  localparam int CTL_POLAR  = 0;

  // Load enables the control hands to the datapath, indexed by path.
  typedef struct packed {
    logic [NUM_PATHS-1:0] load;
  } routeStrobes_t;

endpackage

// File: rtl/routeCtrl.sv
module routeCtrl
  import routerPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [CTL_W-1:0] inCtl,
  output routeStrobes_t    strobes,
  output logic             fbValid,
  output logic             agcValid,
  output logic             casValid,
  output logic             agcGainSel,
  output logic             agcUpdate,
  output logic             outStrobe,
  output logic             polarFbReq
);

  pathSel_e pathSel;
  logic     toFb;
  logic     toAgc;
  logic     toCas;
  logic     gainNext;
  logic     updateNext;

  always_comb begin
    pathSel = pathSel_e'(inCtl[CTL_SEL_HI:CTL_SEL_LO]);
    toFb  = 1'b0;
    toAgc = 1'b0;
    toCas = 1'b0;
    unique case (pathSel)
      SEL_FEEDBACK:  toFb  = inValid;
      SEL_AGC:       toAgc = inValid;
      SEL_CASCADE:   toCas = inValid;
      SEL_TEST_BOTH: begin
        toFb  = inValid;
        toCas = inValid;
      end
      default: ;
    endcase
    // AGC controls are only meaningful on the FIFO/AGC path.
    gainNext   = toAgc & inCtl[CTL_GAIN];
    updateNext = toAgc & inCtl[CTL_UPDATE];
  end

  always_comb begin
    strobes = '0;
    strobes.load[IDX_FB]  = toFb;
    strobes.load[IDX_AGC] = toAgc;
    strobes.load[IDX_CAS] = toCas;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fbValid    <= 1'b0;
      agcValid   <= 1'b0;
      casValid   <= 1'b0;
      agcGainSel <= 1'b0;
      agcUpdate  <= 1'b0;
      outStrobe  <= 1'b0;
      polarFbReq <= 1'b0;
    end else begin
      fbValid    <= toFb;
      agcValid   <= toAgc;
      casValid   <= toCas;
      agcGainSel <= gainNext;
      agcUpdate  <= updateNext;
      outStrobe  <= inValid & inCtl[CTL_STROBE];
      polarFbReq <= inValid & inCtl[CTL_POLAR];
    end
  end

endmodule

// File: rtl/routeData.sv
module routeData
  import routerPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  routeStrobes_t     strobes,
  input  logic [DATA_W-1:0] inI,
  input  logic [DATA_W-1:0] inQ,
  input  logic [STEP_W-1:0] inStep,
  output logic [DATA_W-1:0] fbI,
  output logic [DATA_W-1:0] fbQ,
  output logic [STEP_W-1:0] fbStep,
  output logic [DATA_W-1:0] agcI,
  output logic [DATA_W-1:0] agcQ,
  output logic [DATA_W-1:0] casI,
  output logic [DATA_W-1:0] casQ
);

  localparam int PAIR_W = 2 * DATA_W;

  logic [PAIR_W-1:0] pathReg [NUM_PATHS];
  logic [STEP_W-1:0] stepReg;

  // One held I/Q register per destination path; unselected paths keep their contents.
  for (genvar p = 0; p < NUM_PATHS; p++) begin : gPath
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pathReg[p] <= '0;
      end else if (strobes.load[p]) begin
        pathReg[p] <= {inI, inQ};
      end
    end
  end

  // Step number travels only with the recirculated sample.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepReg <= '0;
    end else if (strobes.load[IDX_FB]) begin
      stepReg <= inStep;
    end
  end

  assign fbI    = pathReg[IDX_FB][PAIR_W-1:DATA_W];
  assign fbQ    = pathReg[IDX_FB][DATA_W-1:0];
  assign agcI   = pathReg[IDX_AGC][PAIR_W-1:DATA_W];
  assign agcQ   = pathReg[IDX_AGC][DATA_W-1:0];
  assign casI   = pathReg[IDX_CAS][PAIR_W-1:DATA_W];
  assign casQ   = pathReg[IDX_CAS][DATA_W-1:0];
  assign fbStep = stepReg;

endmodule

// File: rtl/filterDestRouter.sv
module filterDestRouter
  import routerPkg::*;
#(
  parameter int DATA_W = 24,
  parameter int STEP_W = 5,
  localparam int DEST_W = STEP_W + CTL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inI,
  input  logic [DATA_W-1:0] inQ,
  input  logic [DEST_W-1:0] inDest,
  output logic              fbValid,
  output logic [DATA_W-1:0] fbI,
  output logic [DATA_W-1:0] fbQ,
  output logic [STEP_W-1:0] fbStep,
  output logic              agcValid,
  output logic [DATA_W-1:0] agcI,
  output logic [DATA_W-1:0] agcQ,
  output logic              agcGainSel,
  output logic              agcUpdate,
  output logic              casValid,
  output logic [DATA_W-1:0] casI,
  output logic [DATA_W-1:0] casQ,
  output logic              outStrobe,
  output logic              polarFbReq
);

  routeStrobes_t strobes;

  routeCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inCtl      (inDest[DEST_W-1:STEP_W]),
    .strobes    (strobes),
    .fbValid    (fbValid),
    .agcValid   (agcValid),
    .casValid   (casValid),
    .agcGainSel (agcGainSel),
    .agcUpdate  (agcUpdate),
    .outStrobe  (outStrobe),
    .polarFbReq (polarFbReq)
  );

  routeData #(
    .DATA_W (DATA_W),
    .STEP_W (STEP_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inI     (inI),
    .inQ     (inQ),
    .inStep  (inDest[STEP_W-1:0]),
    .fbI     (fbI),
    .fbQ     (fbQ),
    .fbStep  (fbStep),
    .agcI    (agcI),
    .agcQ    (agcQ),
    .casI    (casI),
    .casQ    (casQ)
  );

endmodule

// File: rtl/routerChecker.sv
module routerChecker #(
  parameter int DATA_W = 24,
  parameter int STEP_W = 5,
  localparam int DEST_W = STEP_W + 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [DATA_W-1:0] inI,
  input logic [DEST_W-1:0] inDest,
  input logic              fbValid,
  input logic [DATA_W-1:0] fbI,
  input logic [STEP_W-1:0] fbStep,
  input logic              agcValid,
  input logic [DATA_W-1:0] agcI,
  input logic              agcGainSel,
  input logic              agcUpdate,
  input logic              casValid,
  input logic [DATA_W-1:0] casI,
  input logic              outStrobe,
  input logic              polarFbReq
);

  localparam int SEL_LO = STEP_W + 2;

  // R10: nothing fires after an idle cycle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !(fbValid || agcValid || casValid || agcGainSel ||
                   agcUpdate || outStrobe || polarFbReq));

  // R6: AGC control pulses only accompany an AGC-path sample
  a_r6_agc_gated: assert property (@(posedge clk) disable iff (!rstN)
    (agcGainSel || agcUpdate) |-> agcValid);

  // R3: AGC path is exclusive
  a_r3_agc_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    agcValid |-> !fbValid && !casValid);

  // R5: test mode fans out to feedback and cascade
  a_r5_test_fanout: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inDest[SEL_LO+1:SEL_LO] == 2'b11 |=> fbValid && casValid && !agcValid);

  // R2: feedback data follows the sample that selected it
  a_r2_fb_data: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inDest[SEL_LO+1:SEL_LO] == 2'b00 |=> fbValid && fbI == $past(inI));

  // R7: serial output strobe tracks its field bit
  a_r7_out_strobe: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outStrobe == $past(inDest[STEP_W+1]));

  // R8: polar feedback request tracks its field bit
  a_r8_polar_req: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> polarFbReq == $past(inDest[STEP_W]));

  // R9: step tag matches the sample written into feedback
  a_r9_step_tag: assert property (@(posedge clk) disable iff (!rstN)
    inValid && !inDest[SEL_LO] && !inDest[SEL_LO+1] |=> fbStep == $past(inDest[STEP_W-1:0]));

  // R11: unselected path data holds
  a_r11_agc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !agcValid |-> $stable(agcI));
  a_r11_cas_hold: assert property (@(posedge clk) disable iff (!rstN)
    !casValid |-> $stable(casI));

endmodule

bind filterDestRouter routerChecker #(
  .DATA_W (DATA_W),
  .STEP_W (STEP_W)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inI        (inI),
  .inDest     (inDest),
  .fbValid    (fbValid),
  .fbI        (fbI),
  .fbStep     (fbStep),
  .agcValid   (agcValid),
  .agcI       (agcI),
  .agcGainSel (agcGainSel),
  .agcUpdate  (agcUpdate),
  .casValid   (casValid),
  .casI       (casI),
  .outStrobe  (outStrobe),
  .polarFbReq (polarFbReq)
);

// File: tb/tb_filterDestRouter.sv
module tb_filterDestRouter;

  localparam int DATA_W = 24;
  localparam int STEP_W = 5;
  localparam int DEST_W = STEP_W + 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [DATA_W-1:0] inI = '0;
  logic [DATA_W-1:0] inQ = '0;
  logic [DEST_W-1:0] inDest = '0;
  logic              fbValid, agcValid, casValid;
  logic [DATA_W-1:0] fbI, fbQ, agcI, agcQ, casI, casQ;
  logic [STEP_W-1:0] fbStep;
  logic              agcGainSel, agcUpdate, outStrobe, polarFbReq;

  int checks = 0;
  int failures = 0;

  // Bench-side model of held state
  logic [DATA_W-1:0] mFbI = '0, mFbQ = '0, mAgcI = '0, mAgcQ = '0, mCasI = '0, mCasQ = '0;
  logic [STEP_W-1:0] mStep = '0;

  always #5 clk = ~clk;

  filterDestRouter #(.DATA_W(DATA_W), .STEP_W(STEP_W)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ), .inDest(inDest),
    .fbValid(fbValid), .fbI(fbI), .fbQ(fbQ), .fbStep(fbStep),
    .agcValid(agcValid), .agcI(agcI), .agcQ(agcQ),
    .agcGainSel(agcGainSel), .agcUpdate(agcUpdate),
    .casValid(casValid), .casI(casI), .casQ(casQ),
    .outStrobe(outStrobe), .polarFbReq(polarFbReq)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Field layout: [10] gain, [9] update, [8:7] path, [6] strobe, [5] polar, [4:0] step
  function automatic logic [DEST_W-1:0] mkDest(input logic g, input logic u, input logic [1:0] p,
                                               input logic s, input logic m, input logic [4:0] st);
    return {g, u, p, s, m, st};
  endfunction

  // Drive one cycle at a negedge, then check all outputs at the next negedge.
  task automatic step(input string req, input logic v, input logic [DEST_W-1:0] d,
                      input logic [DATA_W-1:0] i, input logic [DATA_W-1:0] q);
    logic eFb, eAgc, eCas;
    logic [1:0] p;
    inValid = v; inDest = d; inI = i; inQ = q;
    p    = d[8:7];
    eFb  = v && (p == 2'b00 || p == 2'b11);
    eAgc = v && (p == 2'b01);
    eCas = v && (p == 2'b10 || p == 2'b11);
    if (eFb)  begin mFbI = i; mFbQ = q; mStep = d[4:0]; end
    if (eAgc) begin mAgcI = i; mAgcQ = q; end
    if (eCas) begin mCasI = i; mCasQ = q; end
    @(negedge clk);
    check(req, "fbValid",    fbValid,    eFb);
    check(req, "agcValid",   agcValid,   eAgc);
    check(req, "casValid",   casValid,   eCas);
    check(req, "agcGainSel", agcGainSel, eAgc && d[10]);
    check(req, "agcUpdate",  agcUpdate,  eAgc && d[9]);
    check(req, "outStrobe",  outStrobe,  v && d[6]);
    check(req, "polarFbReq", polarFbReq, v && d[5]);
    check(req, "fbI",  fbI,  mFbI);
    check(req, "fbQ",  fbQ,  mFbQ);
    check(req, "fbStep", fbStep, mStep);
    check(req, "agcI", agcI, mAgcI);
    check(req, "agcQ", agcQ, mAgcQ);
    check(req, "casI", casI, mCasI);
    check(req, "casQ", casQ, mCasQ);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    // R1: outputs cleared during and right after reset
    step("R1", 1'b1, mkDest(1, 1, 2'b11, 1, 1, 5'h1f), 24'h123456, 24'h654321);
    check("R1", "fbValid in reset", fbValid, 0);
    check("R1", "fbI in reset", fbI, 0);
  endtask

  task automatic testFeedback();
    step("R2", 1'b1, mkDest(1, 1, 2'b00, 0, 0, 5'd7), 24'h00a001, 24'h00b001); // R6 gating too
    step("R9", 1'b1, mkDest(0, 0, 2'b00, 0, 0, 5'd19), 24'h00a002, 24'h00b002);
  endtask

  task automatic testAgc();
    step("R3", 1'b1, mkDest(1, 0, 2'b01, 0, 0, 5'd3), 24'h0c0001, 24'h0d0001);
    step("R6", 1'b1, mkDest(0, 1, 2'b01, 0, 0, 5'd4), 24'h0c0002, 24'h0d0002);
    step("R6", 1'b1, mkDest(1, 1, 2'b01, 0, 0, 5'd5), 24'h0c0003, 24'h0d0003);
    step("R9", 1'b1, mkDest(0, 0, 2'b01, 0, 0, 5'd30), 24'h0c0004, 24'h0d0004); // step holds
  endtask

  task automatic testCascade();
    step("R4", 1'b1, mkDest(1, 1, 2'b10, 0, 0, 5'd9), 24'hfff001, 24'heee001);
  endtask

  task automatic testBoth();
    step("R5", 1'b1, mkDest(1, 1, 2'b11, 0, 0, 5'd12), 24'h555555, 24'haaaaaa);
  endtask

  task automatic testStrobes();
    step("R7", 1'b1, mkDest(0, 0, 2'b10, 1, 0, 5'd0), 24'h000111, 24'h000222);
    step("R8", 1'b1, mkDest(0, 0, 2'b01, 0, 1, 5'd0), 24'h000333, 24'h000444);
    step("R8", 1'b1, mkDest(0, 0, 2'b00, 1, 1, 5'd21), 24'h000555, 24'h000666);
  endtask

  task automatic testIdle();
    // R10: busy field with no valid; R11: all held data unchanged
    step("R10", 1'b0, mkDest(1, 1, 2'b01, 1, 1, 5'd31), 24'hdeadbe, 24'hbeefde);
    step("R11", 1'b0, mkDest(1, 1, 2'b11, 1, 1, 5'd1), 24'h111111, 24'h222222);
  endtask

  task automatic testBackToBack();
    // R12: each consecutive sample uses its own field
    step("R12", 1'b1, mkDest(0, 0, 2'b00, 0, 1, 5'd2), 24'h100001, 24'h200001);
    step("R12", 1'b1, mkDest(1, 1, 2'b01, 1, 0, 5'd3), 24'h100002, 24'h200002);
    step("R12", 1'b1, mkDest(0, 0, 2'b10, 0, 0, 5'd4), 24'h100003, 24'h200003);
    step("R12", 1'b1, mkDest(0, 1, 2'b11, 1, 1, 5'd5), 24'h100004, 24'h200004);
    step("R11", 1'b1, mkDest(0, 0, 2'b01, 0, 0, 5'd6), 24'h100005, 24'h200005);
    step("R12", 1'b0, '0, '0, '0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // During reset: model expects everything cleared, so reset the model stimulus effect
    inValid = 1'b1; inDest = mkDest(1, 1, 2'b11, 1, 1, 5'h1f); inI = 24'h123456;
    @(negedge clk);
    check("R1", "fbValid", fbValid, 0);
    check("R1", "agcValid", agcValid, 0);
    check("R1", "casValid", casValid, 0);
    check("R1", "outStrobe", outStrobe, 0);
    check("R1", "fbI", fbI, 0);
    check("R1", "fbStep", fbStep, 0);
    inValid = 1'b0;
    rstN = 1'b1;
    step("R1", 1'b0, '0, '0, '0);
    testFeedback();
    testAgc();
    testCascade();
    testBoth();
    testStrobes();
    testIdle();
    testBackToBack();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule